// File: doc/BRIEF.md
# Ethernet Source Address Inserter

This stage sits in a byte-wide transmit path. It writes the station's 48-bit hardware address into the source-address field of every outgoing frame. Upstream sends the destination address first, and then the EtherType and payload. The source address is left out of the upstream stream. The stage forwards the six destination bytes and then emits six address bytes taken from the `station_addr` port. While it does this it stalls upstream through `in_ready`. It then forwards the rest of the frame. When insertion is switched off for a frame, the frame passes through unchanged, and upstream must carry the source address itself.

Every register advances only on cycles where `ce` is high. This lets a fast clock drive a slower line rate. A frame is a run of accepted bytes with `in_valid` high. A `ce` cycle with `in_valid` low, while the stage is not stalling, ends the frame. `ins_en` is taken once, with the first byte of a frame, so a frame never changes mode partway through.

The controller is a four-state machine:
- WAIT: no frame is in progress.
- DEST: the leading destination bytes are being forwarded.
- SPLICE: the address bytes are being emitted and upstream is stalled.
- BODY: the input is passed through to the end of the frame.

Transitions:
- WAIT→DEST: first byte, insertion on.
- WAIT→BODY: first byte, insertion off.
- DEST→SPLICE: sixth byte accepted.
- DEST→WAIT: frame ended early.
- SPLICE→BODY: last address byte emitted.
- BODY→WAIT: valid low.

Top module: `mac_src_insert`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stage returns to WAIT, so the next byte starts a new frame. After that edge `out_valid` is 0 and `in_ready` is 1.
- R2: With insertion on, the output of a frame is the first six input bytes, then six address bytes, then every remaining input byte in order. No input byte is lost or repeated.
- R3: The inserted bytes come from `station_addr` most significant byte first: bits 47:40, then 39:32, and so on down to 7:0. The value used is the one on the port on the `ce` cycle each byte is emitted.
- R4: `in_ready` falls right after the `ce` edge that accepts the sixth byte. It stays low for exactly six `ce` edges. An input byte held during the stall is accepted after the stall ends.
- R5: With insertion off, a frame is forwarded byte for byte, and `in_ready` stays high for the whole frame.
- R6: `ins_en` is sampled only on the `ce` edge that accepts the first byte of a frame. Changes to it later in the frame have no effect on that frame's output.
- R7: On a cycle where `ce` is low, no state changes: `out_valid`, `out_byte` and `in_ready` hold their values.
- R8: A `ce` edge with `in_valid` low and `in_ready` high ends the frame, and `out_valid` is 0 after that edge. A frame shorter than six bytes ends with no insertion, and the next frame starts counting from its first byte.
- R9: An accepted byte appears on `out_byte`, with `out_valid` high, right after the `ce` edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable; all state advances only when high |
| ins_en | input | 1 | Insert the station address into the next frame |
| station_addr | input | 48 | Station hardware address, most significant byte sent first |
| in_valid | input | 1 | Input byte valid; low on a ce cycle ends the frame |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Low while address bytes are being emitted |
| out_valid | output | 1 | Output byte valid (qualify with ce) |
| out_byte | output | 8 | Output byte |

## Verification
The assertions assume the following of upstream:
- It keeps `in_valid` and `in_byte` steady while `in_ready` is low.
- It separates frames with at least one accepted `ce` cycle where `in_valid` is low.
- It changes `station_addr` only when no insertion is under way.

The stimulus is built from a queue. An item leaves the queue only on a `ce` edge with `in_ready` high, which meets all three assumptions. The address is changed only after the queue has drained. `ce` is driven either always high or from a random duty cycle. Frame lengths include the short cases (one byte, three bytes, exactly six bytes) and frames that toggle `ins_en` after the first byte.

// File: rtl/mac_ins_pkg.sv
package mac_ins_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_DEST   = 2'd1,
        ST_SPLICE = 2'd2,
        ST_BODY   = 2'd3
    } ins_state_e;

    // What the output register loads on a ce edge
    typedef enum logic [1:0] {
        EM_NONE = 2'd0,
        EM_PASS = 2'd1,
        EM_ADDR = 2'd2
    } emit_e;

endpackage

// File: rtl/mac_ins_ctrl.sv
module mac_ins_ctrl
    import mac_ins_pkg::*;
#(
    parameter int LEAD_BYTES = 6,
    parameter int ADDR_BYTES = 6,
    parameter int SEL_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             ins_en,
    input  logic             in_valid,
    output logic             in_ready,
    output emit_e            emit,
    output logic [SEL_W-1:0] sel
);

    localparam int CNT_MAX = (LEAD_BYTES > ADDR_BYTES) ? LEAD_BYTES : ADDR_BYTES;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    ins_state_e       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             frame_mode, mode_n;
    logic [CNT_W:0]   stall_run;

    // Next-state and emit decode
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        mode_n  = frame_mode;
        emit    = EM_NONE;
        unique case (state)
            ST_WAIT: begin
                if (in_valid) begin
                    emit   = EM_PASS;
                    mode_n = ins_en;
                    cnt_n  = CNT_W'(1);
                    if (!ins_en) begin
                        state_n = ST_BODY;
                    end else if (LEAD_BYTES == 1) begin
                        state_n = ST_SPLICE;
                        cnt_n   = '0;
                    end else begin
                        state_n = ST_DEST;
                    end
                end
            end
            ST_DEST: begin
                if (in_valid) begin
                    emit = EM_PASS;
                    if (cnt == CNT_W'(LEAD_BYTES - 1)) begin
                        state_n = ST_SPLICE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end else begin
                    state_n = ST_WAIT;
                    cnt_n   = '0;
                end
            end
            ST_SPLICE: begin
                emit = EM_ADDR;
                if (cnt == CNT_W'(ADDR_BYTES - 1)) begin
                    state_n = ST_BODY;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + CNT_W'(1);
                end
            end
            ST_BODY: begin
                if (in_valid) begin
                    emit = EM_PASS;
                end else begin
                    state_n = ST_WAIT;
                    cnt_n   = '0;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_WAIT;
            cnt        <= '0;
            frame_mode <= 1'b0;
        end else if (ce) begin
            state      <= state_n;
            cnt        <= cnt_n;
            frame_mode <= mode_n;
        end
    end

    // Outputs
    always_comb begin
        in_ready = (state != ST_SPLICE);
        sel      = SEL_W'(cnt);
    end

    // Length of the current stall, in ce cycles, for the bound check
    always_ff @(posedge clk) begin
        if (!rst_n || in_ready)
            stall_run <= '0;
        else if (ce)
            stall_run <= stall_run + (CNT_W+1)'(1);
    end

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= (CNT_W+1)'(ADDR_BYTES)); // R4

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && state != ST_WAIT) |=> $stable(frame_mode)); // R6

    AST_NO_STALL_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT && !frame_mode) |-> in_ready); // R5

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SPLICE) |-> (cnt < CNT_W'(ADDR_BYTES))); // R3

endmodule

// File: rtl/mac_ins_addr_mux.sv
module mac_ins_addr_mux #(
    parameter int DATA_W     = 8,
    parameter int ADDR_BYTES = 6,
    parameter int SEL_W      = 3
) (
    input  logic [ADDR_BYTES*DATA_W-1:0] addr,
    input  logic [SEL_W-1:0]             sel,
    output logic [DATA_W-1:0]            addr_byte
);

    logic [DATA_W-1:0] lanes [ADDR_BYTES];

    // Lane 0 holds the most significant byte
    for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_lane
        assign lanes[k] = addr[(ADDR_BYTES-k)*DATA_W-1 -: DATA_W];
    end

    always_comb begin
        addr_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (sel == SEL_W'(k))
                addr_byte = lanes[k];
        end
    end

endmodule

// File: rtl/mac_ins_outreg.sv
module mac_ins_outreg
    import mac_ins_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  emit_e             emit,
    input  logic [DATA_W-1:0] in_byte,
    input  logic [DATA_W-1:0] addr_byte,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_byte
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
        end else if (ce) begin
            out_valid <= (emit != EM_NONE);
            if (emit == EM_ADDR)
                out_byte <= addr_byte;
            else if (emit == EM_PASS)
                out_byte <= in_byte;
        end
    end

    AST_HOLD_WITHOUT_CE: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(out_valid) && $stable(out_byte))); // R7

endmodule

// File: rtl/mac_src_insert.sv
module mac_src_insert
    import mac_ins_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int LEAD_BYTES = 6,
    parameter int ADDR_BYTES = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ce,
    input  logic                         ins_en,
    input  logic [ADDR_BYTES*DATA_W-1:0] station_addr,
    input  logic                         in_valid,
    input  logic [DATA_W-1:0]            in_byte,
    output logic                         in_ready,
    output logic                         out_valid,
    output logic [DATA_W-1:0]            out_byte
);

    localparam int SEL_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    emit_e             emit;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] addr_byte;

    mac_ins_ctrl #(
        .LEAD_BYTES (LEAD_BYTES),
        .ADDR_BYTES (ADDR_BYTES),
        .SEL_W      (SEL_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .ins_en   (ins_en),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .emit     (emit),
        .sel      (sel)
    );

    mac_ins_addr_mux #(
        .DATA_W     (DATA_W),
        .ADDR_BYTES (ADDR_BYTES),
        .SEL_W      (SEL_W)
    ) u_mux (
        .addr      (station_addr),
        .sel       (sel),
        .addr_byte (addr_byte)
    );

    mac_ins_outreg #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce        (ce),
        .emit      (emit),
        .in_byte   (in_byte),
        .addr_byte (addr_byte),
        .out_valid (out_valid),
        .out_byte  (out_byte)
    );

    AST_STALL_EMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !in_ready) |=> out_valid); // R2

    AST_PASS_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && in_valid && in_ready) |=> (out_valid && out_byte == $past(in_byte))); // R9

endmodule

// File: tb/mac_src_insert_test.sv
module mac_src_insert_test;

    typedef struct {
        bit         gap;
        logic [7:0] b;
        bit         en;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        ins_en = 1'b0;
    logic [47:0] station_addr = 48'h0A1B2C3D4E5F;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready;
    logic        out_valid;
    logic [7:0]  out_byte;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int ce_pct = 100;
    string phase = "R1";
    bit checking = 0;

    item_t      stim[$];
    logic [7:0] exp_stream[$];
    bit         acc_pending = 0;

    // reference model state
    int         m_cnt = 0;
    int         m_splice = 0;
    bit         m_mode = 0;
    bit         m_valid = 0;
    logic [7:0] m_byte = 8'h00;
    bit         m_is_addr = 0;
    bit         m_ce_edge = 0;

    mac_src_insert uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce           (ce),
        .ins_en       (ins_en),
        .station_addr (station_addr),
        .in_valid     (in_valid),
        .in_byte      (in_byte),
        .in_ready     (in_ready),
        .out_valid    (out_valid),
        .out_byte     (out_byte)
    );

    always #5 clk = ~clk;

    task automatic report;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model, updated on each rising edge
    always @(posedge clk) begin
        m_ce_edge = rst_n && ce;
        if (!rst_n) begin
            m_cnt = 0; m_splice = 0; m_valid = 0; m_byte = 8'h00; m_is_addr = 0;
        end else if (ce) begin
            if (m_splice > 0) begin
                m_byte    = station_addr[47 - 8*(6 - m_splice) -: 8];
                m_valid   = 1;
                m_is_addr = 1;
                m_splice--;
            end else if (in_valid) begin
                if (m_cnt == 0) m_mode = ins_en;
                m_byte    = in_byte;
                m_valid   = 1;
                m_is_addr = 0;
                m_cnt++;
                if (m_mode && m_cnt == 6) m_splice = 6;
            end else begin
                m_valid = 0;
                m_cnt   = 0;
            end
        end
    end

    // Per-cycle comparison and stream capture
    always @(negedge clk) begin
        if (checking && rst_n) begin
            check(phase, "out_valid", int'(out_valid), int'(m_valid));
            if (m_valid)
                check(m_is_addr ? "R3" : phase, "out_byte", int'(out_byte), int'(m_byte));
            check("R4", "in_ready", int'(in_ready), (m_splice == 0) ? 1 : 0);
            if (m_ce_edge && out_valid) begin
                if (exp_stream.size() == 0) begin
                    check("R2", "extra output byte", 1, 0);
                end else begin
                    check("R2", "stream byte", int'(out_byte), int'(exp_stream[0]));
                    void'(exp_stream.pop_front());
                end
            end
        end
    end

    // Stimulus driver: an item leaves the queue only on an accepted ce edge
    always @(negedge clk) begin
        if (!rst_n) begin
            ce = 0; in_valid = 0; acc_pending = 0;
        end else begin
            if (acc_pending && stim.size() > 0) void'(stim.pop_front());
            ce = ($urandom_range(99) < ce_pct);
            if (stim.size() > 0) begin
                in_valid = !stim[0].gap;
                in_byte  = stim[0].b;
                ins_en   = stim[0].en;
            end else begin
                in_valid = 0;
            end
            acc_pending = ce && in_ready && (stim.size() > 0);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            report();
        end
    end

    task automatic push_frame(int len, bit en_first, bit en_rest, int seed);
        for (int i = 0; i < len; i++) begin
            item_t it;
            it.gap = 0;
            it.b   = 8'((seed * 7 + i * 13 + 1) & 255);
            it.en  = (i == 0) ? en_first : en_rest;
            stim.push_back(it);
            exp_stream.push_back(it.b);
            if (en_first && i == 5)
                for (int k = 0; k < 6; k++)
                    exp_stream.push_back(station_addr[47 - 8*k -: 8]);
        end
        begin
            item_t g;
            g.gap = 1; g.b = 8'h00; g.en = en_rest;
            stim.push_back(g);
        end
    endtask

    task automatic drain;
        while (stim.size() != 0) @(posedge clk);
        repeat (40) @(posedge clk);
        check(phase, "bytes still expected", exp_stream.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_valid in reset", int'(out_valid), 0);
        check("R1", "in_ready in reset", int'(in_ready), 1);
        rst_n = 1;
        checking = 1;
        @(posedge clk);

        phase = "R2";
        push_frame(14, 1, 1, 1);
        push_frame(20, 1, 1, 2);
        drain();

        phase = "R5";
        push_frame(15, 0, 0, 3);
        push_frame(7, 0, 0, 4);
        drain();

        phase = "R8";
        push_frame(3, 1, 1, 5);
        push_frame(1, 1, 1, 6);
        push_frame(6, 1, 1, 7);
        push_frame(9, 1, 1, 8);
        drain();

        phase = "R6";
        push_frame(12, 1, 0, 9);
        push_frame(12, 0, 1, 10);
        drain();

        phase = "R7";
        ce_pct = 40;
        push_frame(16, 1, 1, 11);
        push_frame(10, 0, 1, 12);
        push_frame(6, 1, 0, 13);
        drain();

        phase = "R3";
        station_addr = 48'hF1E2D3C4B5A6;
        @(posedge clk);
        push_frame(13, 1, 1, 14);
        drain();

        phase = "R9";
        ce_pct = 100;
        push_frame(8, 1, 1, 15);
        push_frame(8, 0, 0, 16);
        push_frame(11, 1, 1, 17);
        drain();

        // R1: reset mid-frame, then a fresh frame counts from its first byte
        phase = "R1";
        push_frame(9, 1, 1, 18);
        repeat (3) @(posedge clk);
        checking = 0;
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        stim.delete();
        exp_stream.delete();
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);
        check("R1", "in_ready after reset", int'(in_ready), 1);
        rst_n = 1;
        checking = 1;
        @(posedge clk);
        push_frame(10, 1, 1, 19);
        drain();

        report();
    end

endmodule